// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

The block sends two-channel audio as a bus master. It generates its own bit clock and frame clock from a half-period strobe and shifts samples out MSB first on a single data line. A four-entry word queue sits in front of the shifter. A control agent writes packed sample words into the queue. The transmitter starts with the first accepted write made while the run input is high, and it keeps sending whole frames until run drops.

Four settings are captured on the write that starts a transmission: the word-length code, the framing delay, the frame-clock polarity and the bit-clock inversion. The framing delay selects I2S timing, where data trails the frame clock by one bit, or left-justified timing, where data lines up with the frame clock. 16-bit audio uses a 32-bit-clock frame, and one queue word holds both channels. 20-bit and 24-bit audio use a 48-bit-clock frame, and each queue word holds one channel. A sticky flag reports a starved queue and another reports a dropped write.

Top module: `stereo_serializer`

## Requirements
- R1: After reset, sck=0, fsync=1, sdata=0, busy=0, underflow=0 and overflow=0.
- R2: busy rises on the clock edge that accepts a write while run=1, provided word_code is 0, 4 or 8. A write with run=0, or with any other code, does not start a transmission.
- R3: While busy, sck toggles once per bit_tick and holds its value otherwise. Outside a transmission sck rests low. Both levels are inverted when edge_inv was 1 at start.
- R4: With word_code 0, a frame is 32 bit periods. The left sample is bits 15:0 of one queue word and the right sample is bits 31:16. Each is sent MSB first in a 16-bit slot, and words are consumed in write order.
- R5: With word_code 4 (20-bit) or 8 (24-bit), a frame is 48 bit periods with 24-bit slots. The left and right channels each take their own queue word, in write order. Each sample is right-aligned in its word and sent MSB first, and the unused slot bits are 0.
- R6: With i2s_delay=1, each data bit appears one bit period after the left-justified position, so the first bit of a slot follows the fsync change by one bit. With i2s_delay=0, the first bit coincides with the fsync change.
- R7: fsync is low during the left slot and high during the right slot when frame_pol=0, and the other way round when frame_pol=1. It rests at the right-slot level when idle.
- R8: If the queue is empty when a slot needs a word, that word's samples are sent as zeros and underflow sets. The flag stays set until reset.
- R9: A write to a full four-entry queue is dropped and sets overflow. The flag stays set until reset.
- R10: After run falls, busy stays high until the current frame ends. Then busy falls and sdata rests at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | Half-bit-period strobe |
| run | input | 1 | Enables start and continuation of frames |
| i2s_delay | input | 1 | 1: I2S one-bit delay, 0: left-justified |
| frame_pol | input | 1 | Inverts frame clock level |
| edge_inv | input | 1 | Inverts bit clock |
| word_code | input | 4 | Sample length code: 0=16, 4=20, 8=24 bits |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 32 | Queue write word |
| sck | output | 1 | Bit clock |
| fsync | output | 1 | Frame (channel select) clock |
| sdata | output | 1 | Serial data |
| busy | output | 1 | Transmission in progress |
| underflow | output | 1 | Sticky starved-queue flag |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
A wrong bit position or half-phase state moves the sck, fsync or sdata edges, and the fault shows on the pins within one bit period. A wrong queue pointer or sample register sends the wrong data bits. That fault appears only in the first slot loaded after the corruption, which can be up to one frame away. The bench therefore compares every output on every cycle against a reference that rebuilds each frame's bit pattern from the words it has seen written. A stop-condition fault shows as busy and the clocks running past the frame end, or halting inside a frame.

// File: rtl/aser_pkg.sv
package aser_pkg;

  localparam int SLOT_MAX  = 24;
  localparam int FRAME_MAX = 2 * SLOT_MAX;
  localparam int POS_W     = $clog2(FRAME_MAX);

  typedef logic [POS_W-1:0] pos_t;

  typedef enum logic [3:0] {
    WL_16 = 4'd0,
    WL_20 = 4'd4,
    WL_24 = 4'd8
  } wlen_e;

  typedef struct packed {
    logic       delay;
    logic       pol;
    logic       inv;
    logic [3:0] code;
  } cfg_t;

  function automatic logic code_ok(input logic [3:0] c);
    return (c == WL_16) || (c == WL_20) || (c == WL_24);
  endfunction

  function automatic logic is_wide(input logic [3:0] c);
    return c != WL_16;
  endfunction

  function automatic logic [4:0] sample_width(input logic [3:0] c);
    case (c)
      WL_20:   return 5'd20;
      WL_24:   return 5'd24;
      default: return 5'd16;
    endcase
  endfunction

  function automatic pos_t slot_len(input logic [3:0] c);
    return is_wide(c) ? pos_t'(SLOT_MAX) : pos_t'(16);
  endfunction

  function automatic pos_t frame_last(input logic [3:0] c);
    return is_wide(c) ? pos_t'(FRAME_MAX - 1) : pos_t'(31);
  endfunction

  function automatic logic [SLOT_MAX-1:0] mask_sample(input logic [31:0] word,
                                                      input logic [4:0]  w);
    logic [SLOT_MAX-1:0] m;
    m = {SLOT_MAX{1'b1}} >> (5'd24 - w);
    return word[SLOT_MAX-1:0] & m;
  endfunction

  function automatic logic slot_bit(input logic [SLOT_MAX-1:0] s,
                                    input logic [4:0]          w,
                                    input pos_t                k);
    logic [4:0] idx;
    if (k < {1'b0, w}) begin
      idx = w - 5'(k) - 5'd1;
      return s[idx];
    end
    return 1'b0;
  endfunction

endpackage

// File: rtl/aser_fifo.sv
module aser_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full,
  output logic          drop_evt
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          push_ok;

  assign empty    = (cnt == '0);
  assign full     = (cnt == CW'(DEPTH));
  assign push_ok  = push && !full;
  assign drop_evt = push && full;
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) begin
        mem[wr_ptr] <= push_data;
        wr_ptr      <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      end
      if (pop) begin
        rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      end
      case ({push_ok, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/aser_bitclk.sv
module aser_bitclk
  import aser_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  input  logic run,
  input  pos_t start_last,
  input  pos_t run_last,
  output logic active,
  output logic half,
  output pos_t np,
  output logic step,
  output logic stop_evt
);
  pos_t pos;
  logic fall_tick;
  logic wrap;

  assign np        = (pos == run_last) ? '0 : pos + pos_t'(1);
  assign fall_tick = active && tick && half;
  assign wrap      = fall_tick && (np == '0);
  assign stop_evt  = wrap && !run;
  assign step      = fall_tick && !stop_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      half   <= 1'b0;
      pos    <= '0;
    end else if (start) begin
      active <= 1'b1;
      half   <= 1'b1;
      pos    <= start_last;
    end else if (stop_evt) begin
      active <= 1'b0;
      half   <= 1'b0;
    end else if (active && tick) begin
      half <= ~half;
      if (half) pos <= np;
    end
  end
endmodule

// File: rtl/aser_serial.sv
module aser_serial
  import aser_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        step,
  input  logic        stop_evt,
  input  pos_t        np,
  input  cfg_t        cfg,
  input  logic [31:0] head,
  input  logic        empty,
  output logic        pop,
  output logic        under_evt,
  output logic        sd,
  output logic        ws_right
);
  logic [SLOT_MAX-1:0] left_q, right_q, nl, nr;
  logic [4:0]          w;
  pos_t                slot, k;
  logic                wide, load_l, load_r, ch_r, lj, prev_lj;

  always_comb begin
    w      = sample_width(cfg.code);
    slot   = slot_len(cfg.code);
    wide   = is_wide(cfg.code);
    load_l = step && (np == '0);
    load_r = step && wide && (np == slot);
    nl     = left_q;
    nr     = right_q;
    if (load_l) begin
      if (empty) begin
        nl = '0;
        if (!wide) nr = '0;
      end else if (wide) begin
        nl = mask_sample(head, w);
      end else begin
        nl = {{(SLOT_MAX-16){1'b0}}, head[15:0]};
        nr = {{(SLOT_MAX-16){1'b0}}, head[31:16]};
      end
    end
    if (load_r) nr = empty ? '0 : mask_sample(head, w);
    ch_r      = (np >= slot);
    k         = ch_r ? np - slot : np;
    lj        = slot_bit(ch_r ? nr : nl, w, k);
    pop       = (load_l || load_r) && !empty;
    under_evt = (load_l || load_r) && empty;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q   <= '0;
      right_q  <= '0;
      prev_lj  <= 1'b0;
      sd       <= 1'b0;
      ws_right <= 1'b1;
    end else if (start || stop_evt) begin
      left_q   <= '0;
      right_q  <= '0;
      prev_lj  <= 1'b0;
      sd       <= 1'b0;
      ws_right <= 1'b1;
    end else if (step) begin
      left_q   <= nl;
      right_q  <= nr;
      prev_lj  <= lj;
      sd       <= cfg.delay ? prev_lj : lj;
      ws_right <= ch_r;
    end
  end
endmodule

// File: rtl/stereo_serializer.sv
module stereo_serializer
  import aser_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_tick,
  input  logic        run,
  input  logic        i2s_delay,
  input  logic        frame_pol,
  input  logic        edge_inv,
  input  logic [3:0]  word_code,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic        sck,
  output logic        fsync,
  output logic        sdata,
  output logic        busy,
  output logic        underflow,
  output logic        overflow
);
  localparam int DW = 32;

  cfg_t          cfg_q, cfg_live;
  logic          start_evt, stop_evt, step_evt;
  logic          pop_evt, under_evt, drop_evt;
  logic          fifo_empty, fifo_full;
  logic [DW-1:0] fifo_head;
  logic          active, half, sd, ws_right;
  pos_t          np;

  assign cfg_live  = '{delay: i2s_delay, pol: frame_pol, inv: edge_inv, code: word_code};
  assign start_evt = run && wr_en && !active && code_ok(word_code);

  aser_fifo #(.DEPTH(FIFO_DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(wr_en), .push_data(wr_data), .pop(pop_evt),
    .head(fifo_head), .empty(fifo_empty), .full(fifo_full), .drop_evt(drop_evt)
  );

  aser_bitclk u_clk (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .start(start_evt), .run(run),
    .start_last(frame_last(word_code)), .run_last(frame_last(cfg_q.code)),
    .active(active), .half(half), .np(np), .step(step_evt), .stop_evt(stop_evt)
  );

  aser_serial u_ser (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .step(step_evt), .stop_evt(stop_evt),
    .np(np), .cfg(cfg_q), .head(fifo_head), .empty(fifo_empty),
    .pop(pop_evt), .under_evt(under_evt), .sd(sd), .ws_right(ws_right)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      underflow <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      if (start_evt) cfg_q <= cfg_live;
      if (under_evt) underflow <= 1'b1;
      if (drop_evt)  overflow  <= 1'b1;
    end
  end

  assign sck   = half ^ cfg_q.inv;
  assign fsync = ws_right ^ cfg_q.pol;
  assign sdata = sd;
  assign busy  = active;
endmodule

// File: rtl/stereo_serializer_chk.sv
module stereo_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic run,
  input logic wr_en,
  input logic sck,
  input logic fsync,
  input logic sdata,
  input logic busy,
  input logic underflow,
  input logic overflow,
  input logic under_evt,
  input logic fifo_full
);
  AST_BUSY_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(run && wr_en)); // R2
  AST_LINES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_tick) |=> ($stable(sck) && $stable(fsync) && $stable(sdata))); // R3
  AST_UNDERFLOW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    under_evt |=> underflow); // R8
  AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow); // R8
  AST_OVERFLOW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fifo_full) |=> overflow); // R9
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R9
  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sdata == 1'b0)); // R10
endmodule

bind stereo_serializer stereo_serializer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .run(run), .wr_en(wr_en),
  .sck(sck), .fsync(fsync), .sdata(sdata), .busy(busy),
  .underflow(underflow), .overflow(overflow),
  .under_evt(under_evt), .fifo_full(fifo_full)
);

// File: tb/stereo_serializer_test.sv
module stereo_serializer_test;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0;
  logic        run = 1'b0;
  logic        i2s_delay = 1'b0;
  logic        frame_pol = 1'b0;
  logic        edge_inv = 1'b0;
  logic [3:0]  word_code = 4'd0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        sck, fsync, sdata, busy, underflow, overflow;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  string cur_req = "R1";

  // reference model state
  bit          m_active, m_half, m_wsr, m_sd, m_prev, m_under, m_over;
  bit          c_delay, c_pol, c_inv;
  int          m_pos, m_fl, m_slot, m_w;
  logic [31:0] q[$];
  bit          fb[0:47];

  stereo_serializer uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .run(run),
    .i2s_delay(i2s_delay), .frame_pol(frame_pol), .edge_inv(edge_inv),
    .word_code(word_code), .wr_en(wr_en), .wr_data(wr_data),
    .sck(sck), .fsync(fsync), .sdata(sdata), .busy(busy),
    .underflow(underflow), .overflow(overflow)
  );

  always #2 clk = ~clk;

  always @(negedge clk) bit_tick <= ~bit_tick;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 100000", cyc);
      finish_run();
    end
  end

  task automatic fill_slot(input int base, input longint val);
    for (int k = 0; k < m_slot; k++)
      fb[base + k] = (k < m_w) ? bit'((val >> (m_w - 1 - k)) & 1) : 1'b0;
  endtask

  task automatic load_word(input int base, input bit both);
    logic [31:0] w;
    if (q.size() == 0) begin
      m_under = 1'b1;
      fill_slot(base, 0);
      if (both) fill_slot(m_slot, 0);
    end else begin
      w = q.pop_front();
      if (both) begin
        fill_slot(0, longint'(w[15:0]));
        fill_slot(m_slot, longint'(w[31:16]));
      end else begin
        fill_slot(base, longint'(w) & ((longint'(1) << m_w) - 1));
      end
    end
  endtask

  always @(posedge clk) begin
    bit full0;
    int np;
    bit lj;
    if (!rst_n) begin
      m_active = 0; m_half = 0; m_wsr = 1; m_sd = 0; m_prev = 0;
      m_under = 0; m_over = 0; c_delay = 0; c_pol = 0; c_inv = 0;
      m_pos = 0; m_fl = 32; m_slot = 16; m_w = 16;
      q.delete();
    end else begin
      full0 = (q.size() == DEPTH);
      if (!m_active) begin
        if (run && wr_en && (word_code == 0 || word_code == 4 || word_code == 8)) begin
          m_active = 1; m_half = 1;
          c_delay = i2s_delay; c_pol = frame_pol; c_inv = edge_inv;
          m_fl = (word_code == 0) ? 32 : 48;
          m_slot = m_fl / 2;
          m_w = (word_code == 0) ? 16 : (word_code == 4) ? 20 : 24;
          m_pos = m_fl - 1; m_wsr = 1; m_sd = 0; m_prev = 0;
        end
      end else if (bit_tick) begin
        if (!m_half) m_half = 1;
        else begin
          m_half = 0;
          np = (m_pos + 1) % m_fl;
          if (np == 0 && !run) begin
            m_active = 0; m_wsr = 1; m_sd = 0; m_prev = 0;
          end else begin
            if (np == 0) load_word(0, m_fl == 32);
            else if (m_fl == 48 && np == m_slot) load_word(m_slot, 1'b0);
            lj = fb[np];
            m_sd = c_delay ? m_prev : lj;
            m_prev = lj;
            m_wsr = (np >= m_slot);
            m_pos = np;
          end
        end
      end
      if (wr_en) begin
        if (full0) m_over = 1;
        else q.push_back(wr_data);
      end
    end
  end

  task automatic cmp(input string sig, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", cur_req, sig, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cmp("sck", sck, m_half ^ c_inv);
      cmp("fsync", fsync, m_wsr ^ c_pol);
      cmp("sdata", sdata, m_sd);
      cmp("busy", busy, m_active);
      cmp("underflow", underflow, m_under);
      cmp("overflow", overflow, m_over);
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    run = 1'b0;
    wr_en = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic setup(input logic d, input logic p, input logic inv, input logic [3:0] code);
    i2s_delay = d; frame_pol = p; edge_inv = inv; word_code = code;
  endtask

  initial begin
    do_reset();
    cur_req = "R1";
    chk("R1", "sck", sck, 1'b0);
    chk("R1", "fsync", fsync, 1'b1);
    chk("R1", "sdata", sdata, 1'b0);
    chk("R1", "busy", busy, 1'b0);
    chk("R1", "flags", underflow | overflow, 1'b0);

    // R2: start conditions
    cur_req = "R2";
    setup(0, 0, 0, 4'd2);
    wr(32'h1111_2222);
    wait_cyc(3);
    chk("R2", "busy with bad code", busy, 1'b0);
    run = 1'b1;
    wr(32'h3333_4444);
    wait_cyc(3);
    chk("R2", "busy with bad code and run", busy, 1'b0);
    word_code = 4'd0;
    wr(32'h5555_6666);
    chk("R2", "busy after valid start", busy, 1'b1);
    run = 1'b0;
    wait_cyc(20);
    chk("R10", "busy after stop in pre-roll", busy, 1'b0);

    // R4: 16-bit left-justified
    do_reset();
    cur_req = "R4";
    setup(0, 0, 0, 4'd0);
    run = 1'b1;
    wr(32'hA5C3_1E0F); wr(32'h8001_7FFE); wr(32'h0F0F_F0F0);
    wait_cyc(300);
    run = 1'b0;
    chk("R10", "busy held after run falls", busy, 1'b1);
    wait_cyc(200);
    chk("R10", "idle after frame end", busy, 1'b0);
    chk("R4", "no underflow", underflow, 1'b0);

    // R6, R7, R3: I2S, inverted polarity and bit clock
    do_reset();
    cur_req = "R6";
    setup(1, 1, 1, 4'd0);
    run = 1'b1;
    wr(32'hC001_D00D); wr(32'h1234_8765); wr(32'hFFFF_0001);
    wait_cyc(300);
    cur_req = "R7";
    run = 1'b0;
    wait_cyc(200);
    cur_req = "R3";
    chk("R3", "sck rests inverted", sck, 1'b1);
    chk("R7", "fsync rests at right level", fsync, 1'b0);

    // R5: 24-bit left-justified
    do_reset();
    cur_req = "R5";
    setup(0, 0, 0, 4'd8);
    run = 1'b1;
    wr(32'hFF80_0001); wr(32'h00AB_CDEF); wr(32'h0012_3456); wr(32'hEE7F_FFFF);
    wait_cyc(300);
    run = 1'b0;
    wait_cyc(250);
    chk("R5", "busy after 24-bit run", busy, 1'b0);

    // R5 + R6: 20-bit I2S
    do_reset();
    setup(1, 0, 0, 4'd4);
    run = 1'b1;
    wr(32'hFFFF_FFFF); wr(32'h0008_0001); wr(32'h000A_5A5A); wr(32'h1234_5678);
    wait_cyc(300);
    run = 1'b0;
    wait_cyc(250);
    chk("R5", "no underflow in 20-bit", underflow, 1'b0);

    // R8: starved queue
    do_reset();
    cur_req = "R8";
    setup(0, 0, 0, 4'd0);
    run = 1'b1;
    wr(32'hDEAD_BEEF);
    wait_cyc(350);
    chk("R8", "underflow set", underflow, 1'b1);
    run = 1'b0;
    wait_cyc(200);
    chk("R8", "underflow sticky", underflow, 1'b1);
    chk("R8", "sdata zero idle", sdata, 1'b0);

    // R9: overflow and drop
    do_reset();
    cur_req = "R9";
    setup(0, 0, 0, 4'd0);
    for (int i = 0; i < 5; i++) wr(32'h0101_0101 * (i + 1));
    @(negedge clk);
    chk("R9", "overflow set", overflow, 1'b1);
    chk("R2", "no start without run", busy, 1'b0);
    run = 1'b1;
    wr(32'h7777_7777);
    chk("R2", "start with full queue", busy, 1'b1);
    wait_cyc(620);
    run = 1'b0;
    wait_cyc(200);
    chk("R9", "overflow sticky", overflow, 1'b1);
    chk("R8", "underflow after drained", underflow, 1'b1);

    finish_run();
  end
endmodule